// File: doc/BRIEF.md
# Budgeted Round-Robin DRAM Slot Scheduler

This block decides, slot by slot, which of several on-chip clients may use one external page-mode DRAM. A memory slot lasts two system clocks. Clients take turns in ascending index order, wrapping around. Each turn lasts for a programmable number of slots, called the budget. A client that is not requesting when its turn comes is passed over at once.

The block keeps track of which DRAM page is open. A page is the row field of the address together with the transfer direction. When the next access needs a different page, the block first spends two slots on page-open commands. Those slots are charged to the budget of the client that caused them.

A free-running period counter does three things. It raises a sticky flag for every client that received fewer than two accesses in a period. It schedules refresh commands to a fixed page every programmable number of periods. It is also the limit used to check whether the configured budgets fit in one period.

When the block is not in operating mode, nothing is issued. When the bus is lent to another owner, the DRAM-facing outputs float and the open page is forgotten.

Top module: `dram_rr_sched`

## Requirements
- R1: A DRAM command (code 1 access, 2 page open, 3 refresh; 0 idle) appears on `dram_cmd_o` for a single clock and never in two consecutive clocks. A client streaming to one open page gets accesses exactly two clocks apart.
- R2: An access whose row field differs from that of the open page is preceded by page-open commands. The row field is the top ROW_W bits of the address, 9 by default.
- R3: An access with an unchanged row but the opposite direction from the open page also causes a page transition. A direction is read when `we` is 0 and write when it is 1. The first access after reset also causes a transition.
- R4: A page transition issues exactly PEN (2) page-open commands. The first of them carries the new row (column bits zero) and raises `page_trans_o`. The access follows in the next slot. Each page-open slot uses up one unit of the requesting client's budget.
- R5: Turns pass in ascending client index, wrapping from the last client to client 0. A turn grants up to `budget` accesses to one client. `grant_o` is one-hot and is set exactly in the clock that carries an access command.
- R6: A client whose request is low, or whose budget is zero, when its turn would begin is skipped in that same slot. A client that drops its request mid-turn loses its remaining budget.
- R7: At the end of every PERIOD-clock period, `underserve_o[i]` is set for each client that received fewer than MIN_SVC (2) grants during it. The flag stays set until reset.
- R8: `budget_err_o` is high exactly when two clocks times the sum of all budgets exceeds PERIOD.
- R9: Every `ref_interval_i` periods a refresh request is raised. It is served at the next free slot, ahead of any client, as code 3 with address {REF_ROW, zeros}. The refresh moves the open page, so the next client access starts with a transition.
- R10: While `op_mode_i` is low, no command of any kind is issued, including refresh. Refresh requests raised in the meantime are served first once the mode returns.
- R11: While `share_i` is high, `dram_cmd_o`, `dram_addr_o` and `dram_we_o` are high impedance and no grant is given. After release, the first access starts with a page transition.
- R12: After reset there are no grants, no commands, no underservice flags and no page transition flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_mode_i | input | 1 | Operating mode enable |
| share_i | input | 1 | Lend the DRAM bus to another owner |
| ref_interval_i | input | REF_W | Periods between refresh requests (256 typical) |
| budget_i | input | NCLI*BUD_W | Per-client slot budget, client 0 in the low bits |
| req_i | input | NCLI | Per-client request |
| addr_i | input | NCLI*AW | Per-client word address |
| we_i | input | NCLI | Per-client direction, 1 is write |
| grant_o | output | NCLI | One-hot access grant |
| dram_cmd_o | output | 2 | Command code, floating while shared |
| dram_addr_o | output | AW | Command address, floating while shared |
| dram_we_o | output | 1 | Command direction, floating while shared |
| page_trans_o | output | 1 | Pulse with the first page-open command of a transition |
| underserve_o | output | NCLI | Sticky per-client underservice flags |
| budget_err_o | output | 1 | Budgets do not fit in one period |

## Verification
The bench builds the block with three clients, a 12-bit address that keeps the 9-bit row field, a 4-bit budget, a 40-clock period and a 5-bit refresh interval. The short period lets underservice evaluation and refresh spacing repeat many times within a few hundred clocks. With only three address bits below the row field, both row changes and same-row column changes are easy to produce. A 4-bit budget lets the sum cross the period limit with two clients, so the exact boundary (sum 20 passes, 21 fails) can be exercised.

// File: rtl/dsched_pkg.sv
package dsched_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE = 2'd0,
    CMD_ACC  = 2'd1,
    CMD_PAGE = 2'd2,
    CMD_REF  = 2'd3
  } dcmd_e;
endpackage

// File: rtl/dsched_period_timer.sv
module dsched_period_timer #(
  parameter int PERIOD = 650,
  parameter int REF_W  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REF_W-1:0] ref_interval_i,
  output logic             slot_en_o,
  output logic             wrap_o,
  output logic             ref_due_o
);
  localparam int PC_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic             phase_q;
  logic [PC_W-1:0]  pcnt_q;
  logic [REF_W-1:0] rcnt_q;

  function automatic logic interval_done(input logic [REF_W-1:0] seen,
                                         input logic [REF_W-1:0] lim);
    return ({1'b0, seen} + 1'b1) >= {1'b0, lim};
  endfunction

  assign slot_en_o = !phase_q;
  assign wrap_o    = (pcnt_q == PC_W'(PERIOD - 1));
  assign ref_due_o = wrap_o && interval_done(rcnt_q, ref_interval_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      pcnt_q  <= '0;
      rcnt_q  <= '0;
    end else begin
      phase_q <= !phase_q;
      pcnt_q  <= wrap_o ? '0 : pcnt_q + 1'b1;
      if (wrap_o) rcnt_q <= ref_due_o ? '0 : rcnt_q + 1'b1;
    end
  end

  // R9
  ref_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_due_o |=> (pcnt_q == '0));
endmodule

// File: rtl/dsched_page_track.sv
module dsched_page_track #(
  parameter int ROW_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             forget_i,
  input  logic             open_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic             dir_i,
  output logic             trans_o,
  output logic [ROW_W-1:0] row_o,
  output logic             dir_o
);
  logic             valid_q;
  logic [ROW_W-1:0] row_q;
  logic             dir_q;

  function automatic logic page_differs(input logic v,
                                        input logic [ROW_W-1:0] r_old,
                                        input logic [ROW_W-1:0] r_new,
                                        input logic d_old, input logic d_new);
    return !v || (r_old != r_new) || (d_old != d_new);
  endfunction

  assign trans_o = page_differs(valid_q, row_q, row_i, dir_q, dir_i);
  assign row_o   = row_q;
  assign dir_o   = dir_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      row_q   <= '0;
      dir_q   <= 1'b0;
    end else if (forget_i) begin
      valid_q <= 1'b0;
    end else if (open_i) begin
      valid_q <= 1'b1;
      row_q   <= row_i;
      dir_q   <= dir_i;
    end
  end

  // R2 R3
  reopen_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(open_i) && !$past(forget_i) && !forget_i &&
     $stable(row_i) && $stable(dir_i)) |-> !trans_o);
endmodule

// File: rtl/dsched_service_mon.sv
module dsched_service_mon #(
  parameter int NCLI    = 4,
  parameter int MIN_SVC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCLI-1:0] grant_i,
  input  logic            wrap_i,
  output logic [NCLI-1:0] under_o
);
  localparam int SC_W = $clog2(MIN_SVC + 1);

  function automatic logic [SC_W-1:0] sat_inc(input logic [SC_W-1:0] c, input logic g);
    return (g && (c < SC_W'(MIN_SVC))) ? c + 1'b1 : c;
  endfunction

  generate
    for (genvar i = 0; i < NCLI; i++) begin : g_cli
      logic [SC_W-1:0] cnt_q;
      logic [SC_W-1:0] cnt_n;
      logic            flag_q;

      assign cnt_n      = sat_inc(cnt_q, grant_i[i]);
      assign under_o[i] = flag_q;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          cnt_q  <= '0;
          flag_q <= 1'b0;
        end else if (wrap_i) begin
          cnt_q <= '0;
          if (cnt_n < SC_W'(MIN_SVC)) flag_q <= 1'b1;
        end else begin
          cnt_q <= cnt_n;
        end
      end

      // R7
      under_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_q |=> flag_q);
    end
  endgenerate
endmodule

// File: rtl/dram_rr_sched.sv
module dram_rr_sched
  import dsched_pkg::*;
#(
  parameter int NCLI    = 4,
  parameter int AW      = 18,
  parameter int ROW_W   = 9,
  parameter int BUD_W   = 5,
  parameter int PERIOD  = 650,
  parameter int MIN_SVC = 2,
  parameter int PEN     = 2,
  parameter int REF_W   = 10,
  parameter int REF_ROW = 511
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  op_mode_i,
  input  logic                  share_i,
  input  logic [REF_W-1:0]      ref_interval_i,
  input  logic [NCLI*BUD_W-1:0] budget_i,
  input  logic [NCLI-1:0]       req_i,
  input  logic [NCLI*AW-1:0]    addr_i,
  input  logic [NCLI-1:0]       we_i,
  output logic [NCLI-1:0]       grant_o,
  output logic [1:0]            dram_cmd_o,
  output logic [AW-1:0]         dram_addr_o,
  output logic                  dram_we_o,
  output logic                  page_trans_o,
  output logic [NCLI-1:0]       underserve_o,
  output logic                  budget_err_o
);
  localparam int CI_W      = (NCLI > 1) ? $clog2(NCLI) : 1;
  localparam int COL_W     = AW - ROW_W;
  localparam int PEN_W     = $clog2(PEN + 1);
  localparam int SUM_W     = BUD_W + $clog2(NCLI + 1);
  localparam int SLOT_CLKS = 2;

  // ---------------- arithmetic helpers ----------------
  function automatic logic [CI_W-1:0] rr_next(input logic [CI_W-1:0] from,
                                              input logic [NCLI-1:0] elig);
    logic [CI_W-1:0] pick;
    pick = from;
    for (int k = NCLI; k >= 1; k--) begin
      int idx;
      idx = (int'(from) + k) % NCLI;
      if (elig[idx]) pick = CI_W'(idx);
    end
    return pick;
  endfunction

  function automatic logic [BUD_W-1:0] dec_sat(input logic [BUD_W-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  function automatic logic [SUM_W-1:0] budget_total(input logic [NCLI*BUD_W-1:0] b);
    logic [SUM_W-1:0] s;
    s = '0;
    for (int i = 0; i < NCLI; i++) s = s + SUM_W'(b[i*BUD_W +: BUD_W]);
    return s;
  endfunction

  // ---------------- per-client views ----------------
  logic [BUD_W-1:0] bud     [NCLI];
  logic [AW-1:0]    cl_addr [NCLI];
  logic [NCLI-1:0]  elig;

  generate
    for (genvar i = 0; i < NCLI; i++) begin : g_view
      assign bud[i]     = budget_i[i*BUD_W +: BUD_W];
      assign cl_addr[i] = addr_i[i*AW +: AW];
      assign elig[i]    = req_i[i] && (budget_i[i*BUD_W +: BUD_W] != '0);
    end
  endgenerate

  assign budget_err_o = (SLOT_CLKS * int'(budget_total(budget_i))) > PERIOD;

  // ---------------- timing and monitors ----------------
  logic slot_en, period_wrap, ref_due;

  dsched_period_timer #(.PERIOD(PERIOD), .REF_W(REF_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .ref_interval_i(ref_interval_i),
    .slot_en_o(slot_en), .wrap_o(period_wrap), .ref_due_o(ref_due));

  // ---------------- state ----------------
  logic [CI_W-1:0]  cur_q, cur_n, cand;
  logic [BUD_W-1:0] rem_q, rem_n, cand_rem;
  logic [PEN_W-1:0] pen_q, pen_n;
  logic             ref_pend_q;
  dcmd_e            cmd_q, cmd_n;
  logic [AW-1:0]    addr_q, addr_n;
  logic             we_q, we_n;
  logic [NCLI-1:0]  gnt_q, gnt_n;
  logic             ptr_q, ptr_n;

  // internal events, named for the assertions
  logic forget, active, pen_go, ref_go, cli_go, acc_go, open_new;
  logic trans;
  logic [ROW_W-1:0] open_row, pt_row, pt_in_row;
  logic             pt_dir, pt_in_dir;

  always_comb begin
    cand     = cur_q;
    cand_rem = rem_q;
    if (rem_q == '0 || !elig[cur_q]) begin
      cand     = rr_next(cur_q, elig);
      cand_rem = bud[cand];
    end
  end

  assign forget   = share_i || !op_mode_i;
  assign active   = slot_en && !forget;
  assign pen_go   = active && (pen_q != '0);
  assign ref_go   = active && (pen_q == '0) && ref_pend_q;
  assign cli_go   = active && (pen_q == '0) && !ref_pend_q && elig[cand];
  assign acc_go   = cli_go && !trans;
  assign open_new = ref_go || (cli_go && trans);

  assign pt_in_row = ref_go ? ROW_W'(REF_ROW) : cl_addr[cand][AW-1 -: ROW_W];
  assign pt_in_dir = ref_go ? 1'b0 : we_i[cand];
  assign open_row  = cl_addr[cand][AW-1 -: ROW_W];

  dsched_page_track #(.ROW_W(ROW_W)) u_page (
    .clk(clk), .rst_n(rst_n), .forget_i(forget), .open_i(open_new),
    .row_i(pt_in_row), .dir_i(pt_in_dir),
    .trans_o(trans), .row_o(pt_row), .dir_o(pt_dir));

  dsched_service_mon #(.NCLI(NCLI), .MIN_SVC(MIN_SVC)) u_svc (
    .clk(clk), .rst_n(rst_n), .grant_i(gnt_q), .wrap_i(period_wrap),
    .under_o(underserve_o));

  always_comb begin
    cur_n  = cur_q;
    rem_n  = rem_q;
    pen_n  = pen_q;
    cmd_n  = CMD_IDLE;
    addr_n = '0;
    we_n   = 1'b0;
    gnt_n  = '0;
    ptr_n  = 1'b0;
    if (forget) begin
      pen_n = '0;
    end else if (pen_go) begin
      cmd_n  = CMD_PAGE;
      addr_n = {pt_row, {COL_W{1'b0}}};
      we_n   = pt_dir;
      pen_n  = pen_q - 1'b1;
      rem_n  = dec_sat(rem_q);
    end else if (ref_go) begin
      cmd_n  = CMD_REF;
      addr_n = {ROW_W'(REF_ROW), {COL_W{1'b0}}};
    end else if (cli_go) begin
      cur_n = cand;
      if (trans) begin
        cmd_n  = CMD_PAGE;
        addr_n = {open_row, {COL_W{1'b0}}};
        we_n   = we_i[cand];
        pen_n  = PEN_W'(PEN - 1);
        rem_n  = dec_sat(cand_rem);
        ptr_n  = 1'b1;
      end else begin
        cmd_n       = CMD_ACC;
        addr_n      = cl_addr[cand];
        we_n        = we_i[cand];
        gnt_n[cand] = 1'b1;
        rem_n       = cand_rem - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q      <= CI_W'(NCLI - 1);
      rem_q      <= '0;
      pen_q      <= '0;
      ref_pend_q <= 1'b0;
      cmd_q      <= CMD_IDLE;
      addr_q     <= '0;
      we_q       <= 1'b0;
      gnt_q      <= '0;
      ptr_q      <= 1'b0;
    end else begin
      cur_q      <= cur_n;
      rem_q      <= rem_n;
      pen_q      <= pen_n;
      ref_pend_q <= ref_due ? 1'b1 : (ref_go ? 1'b0 : ref_pend_q);
      cmd_q      <= cmd_n;
      addr_q     <= addr_n;
      we_q       <= we_n;
      gnt_q      <= gnt_n;
      ptr_q      <= ptr_n;
    end
  end

  assign grant_o      = gnt_q;
  assign page_trans_o = ptr_q;
  assign dram_cmd_o   = share_i ? 2'bzz : cmd_q;
  assign dram_addr_o  = share_i ? {AW{1'bz}} : addr_q;
  assign dram_we_o    = share_i ? 1'bz : we_q;

  // ---------------- assertions ----------------
  // R1
  cmd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q != CMD_IDLE) |=> (cmd_q == CMD_IDLE));
  // R5
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_q));
  // R5
  access_has_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_ACC) |-> ($countones(gnt_q) == 1));
  // R4
  trans_is_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q |-> (cmd_q == CMD_PAGE));
  // R4
  penalty_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pen_q != '0 && slot_en && op_mode_i && !share_i) |=> (cmd_q == CMD_PAGE));
  // R10
  idle_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_mode_i |=> (cmd_q == CMD_IDLE));
  // R11
  share_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    share_i |=> (gnt_q == '0 && cmd_q == CMD_IDLE));
endmodule

// File: tb/dram_rr_sched_test.sv
`timescale 1ns/1ps
module dram_rr_sched_test;
  localparam int NC = 3;
  localparam int AWB = 12;
  localparam int BW = 4;
  localparam int PER = 40;
  localparam int RW = 5;
  localparam logic [11:0] REF_ADDR = 12'hF80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_mode = 1'b1;
  logic share = 1'b0;
  logic [RW-1:0] ref_int = 5'd31;
  logic [NC*BW-1:0] budget = '0;
  logic [NC-1:0] req = '0;
  logic [NC*AWB-1:0] addr = '0;
  logic [NC-1:0] we = '0;
  logic [NC-1:0] grant;
  logic [1:0] dcmd;
  logic [AWB-1:0] daddr;
  logic dwe, ptrans, berr;
  logic [NC-1:0] under;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dram_rr_sched #(.NCLI(NC), .AW(AWB), .ROW_W(9), .BUD_W(BW), .PERIOD(PER),
                  .MIN_SVC(2), .PEN(2), .REF_W(RW), .REF_ROW(496)) uut (
    .clk(clk), .rst_n(rst_n), .op_mode_i(op_mode), .share_i(share),
    .ref_interval_i(ref_int), .budget_i(budget), .req_i(req), .addr_i(addr),
    .we_i(we), .grant_o(grant), .dram_cmd_o(dcmd), .dram_addr_o(daddr),
    .dram_we_o(dwe), .page_trans_o(ptrans), .underserve_o(under),
    .budget_err_o(berr));

  // {addr[11:0], we, expect transition}
  localparam logic [13:0] PG_VEC [10] = '{
    {12'h008, 1'b0, 1'b1}, {12'h00F, 1'b0, 1'b0}, {12'h00F, 1'b1, 1'b1},
    {12'h00A, 1'b1, 1'b0}, {12'h010, 1'b1, 1'b1}, {12'h800, 1'b1, 1'b1},
    {12'h807, 1'b1, 1'b0}, {12'h807, 1'b0, 1'b1}, {12'h000, 1'b0, 1'b1},
    {12'h007, 1'b0, 1'b0}};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int gidx(input logic [NC-1:0] g);
    for (int i = 0; i < NC; i++) if (g[i]) return i;
    return -1;
  endfunction

  task automatic wait_cmd(output logic [1:0] k, output logic [11:0] a, output logic w,
                          output logic [NC-1:0] g, output int at, output logic pt);
    k = 2'd0; a = '0; w = 1'b0; g = '0; at = -1; pt = 1'b0;
    for (int n = 0; n < 500; n++) begin
      @(negedge clk);
      if (dcmd !== 2'b00 && dcmd !== 2'bzz) begin
        k = dcmd; a = daddr; w = dwe; g = grant; at = cyc; pt = ptrans;
        return;
      end
    end
  endtask

  task automatic next_grant(output int who);
    logic [1:0] k; logic [11:0] a; logic w; logic [NC-1:0] g; int at; logic pt;
    who = -1;
    for (int n = 0; n < 20; n++) begin
      wait_cmd(k, a, w, g, at, pt);
      if (k == 2'd1) begin who = gidx(g); return; end
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [1:0] k; logic [11:0] a; logic w; logic [NC-1:0] g; int at; logic pt;
    int who, prev, last_acc, npage, npt, t1, t2, cnt;
    int exp_seq [12] = '{2, 2, 2, 0, 0, 1, 2, 2, 2, 0, 0, 1};
    int skip_seq [9] = '{2, 2, 0, 0, 2, 2, 2, 0, 0};

    // ---- reset state (R12)
    budget = {4'd0, 4'd0, 4'd15};
    do_reset();
    chk(grant == 0, "R12 grant after reset", grant, 0);
    chk(dcmd == 0, "R12 command after reset", dcmd, 0);
    chk(under == 0 && ptrans == 0, "R12 flags after reset", under, 0);

    // ---- page transition table (R1 R2 R3 R4 R5)
    last_acc = -1;
    for (int i = 0; i < 10; i++) begin
      addr[11:0] = PG_VEC[i][13:2];
      we[0] = PG_VEC[i][1];
      req = 3'b001;
      npage = 0; npt = 0; t1 = 0;
      for (int n = 0; n < 8; n++) begin
        wait_cmd(k, a, w, g, at, pt);
        if (k == 2'd2) begin
          if (npage == 0) t1 = a;
          npage++;
          if (pt) npt++;
        end else break;
      end
      chk(k == 2'd1, "R2 R3 access issued", k, 1);
      chk(npage == (PG_VEC[i][0] ? 2 : 0), $sformatf("R2 R3 page cmds vec %0d", i),
          npage, PG_VEC[i][0] ? 2 : 0);
      if (PG_VEC[i][0]) begin
        chk(npt == 1, "R4 page_trans pulse", npt, 1);
        chk(t1 == {PG_VEC[i][13:5], 3'b000}, "R4 page-open row", t1, {PG_VEC[i][13:5], 3'b000});
      end
      chk(a == PG_VEC[i][13:2] && w == PG_VEC[i][1], "R5 access addr/dir", a, PG_VEC[i][13:2]);
      chk(g == 3'b001, "R5 grant", g, 1);
      if (last_acc >= 0)
        chk(at - last_acc == (PG_VEC[i][0] ? 6 : 2), "R1 R4 access spacing",
            at - last_acc, PG_VEC[i][0] ? 6 : 2);
      last_acc = at;
    end

    // ---- round robin with budgets (R4 R5 R7)
    req = 3'b000;
    budget = {4'd3, 4'd1, 4'd2};
    addr = {12'h007, 12'h007, 12'h007};
    we = 3'b000;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    req = 3'b111;
    next_grant(who);
    chk(who == 1, "R4 penalty charged to client 0 budget", who, 1);
    for (int i = 0; i < 12; i++) begin
      next_grant(who);
      chk(who == exp_seq[i], $sformatf("R5 turn order step %0d", i), who, exp_seq[i]);
    end
    repeat (100) @(negedge clk);
    chk(under == 3'b000, "R7 no underservice when all served", under, 0);

    // ---- skip non-requesting client (R6 R7)
    req = 3'b101;
    prev = -1;
    for (int n = 0; n < 20; n++) begin
      next_grant(who);
      if (prev == 0 && who == 2) break;
      prev = who;
    end
    for (int i = 0; i < 9; i++) begin
      next_grant(who);
      chk(who == skip_seq[i], $sformatf("R6 skip order step %0d", i), who, skip_seq[i]);
    end
    repeat (100) @(negedge clk);
    chk(under == 3'b010, "R7 starved client flagged", under, 2);

    // ---- zero budget skipped (R6)
    req = 3'b111;
    budget = {4'd3, 4'd0, 4'd2};
    cnt = 0;
    for (int i = 0; i < 8; i++) begin
      next_grant(who);
      if (who == 1 || who < 0) cnt++;
    end
    chk(cnt == 0, "R6 zero budget client never granted", cnt, 0);

    // ---- refresh (R9)
    budget = {4'd0, 4'd0, 4'd3};
    req = 3'b001;
    ref_int = 5'd2;
    do_reset();
    k = 2'd0;
    for (int n = 0; n < 200 && k != 2'd3; n++) wait_cmd(k, a, w, g, at, pt);
    t1 = at;
    chk(k == 2'd3 && a == REF_ADDR, "R9 refresh command and page", a, REF_ADDR);
    wait_cmd(k, a, w, g, at, pt); npage = (k == 2'd2);
    wait_cmd(k, a, w, g, at, pt); npage += (k == 2'd2);
    wait_cmd(k, a, w, g, at, pt);
    chk(npage == 2 && k == 2'd1, "R9 access after refresh reopens page", npage, 2);
    k = 2'd0;
    for (int n = 0; n < 200 && k != 2'd3; n++) wait_cmd(k, a, w, g, at, pt);
    t2 = at;
    chk(t2 - t1 == 2 * PER, "R9 refresh interval", t2 - t1, 2 * PER);

    // ---- operating mode off (R10)
    op_mode = 1'b0;
    cnt = 0;
    repeat (200) begin
      @(negedge clk);
      if (dcmd !== 2'b00) cnt++;
    end
    chk(cnt == 0, "R10 no commands while not operating", cnt, 0);
    op_mode = 1'b1;
    wait_cmd(k, a, w, g, at, pt);
    chk(k == 2'd3, "R10 pending refresh served first", k, 3);
    ref_int = 5'd31;
    repeat (10) @(negedge clk);

    // ---- bus sharing (R11)
    share = 1'b1;
    cnt = 0;
    @(negedge clk);
    chk(dcmd === 2'bzz && daddr === {AWB{1'bz}} && dwe === 1'bz,
        "R11 outputs float", dcmd, 0);
    repeat (20) begin
      @(negedge clk);
      if (grant !== 3'b000) cnt++;
    end
    chk(cnt == 0, "R11 no grants while shared", cnt, 0);
    share = 1'b0;
    npage = 0;
    for (int n = 0; n < 4; n++) begin
      wait_cmd(k, a, w, g, at, pt);
      if (k == 2'd2) npage++; else break;
    end
    chk(npage == 2 && k == 2'd1, "R11 page reopened after release", npage, 2);

    // ---- budget limit (R8)
    budget = {4'd0, 4'd15, 4'd15};
    #1 chk(berr == 1'b1, "R8 budgets exceed period", berr, 1);
    budget = {4'd0, 4'd10, 4'd10};
    #1 chk(berr == 1'b0, "R8 budgets exactly fill period", berr, 0);
    budget = {4'd1, 4'd10, 4'd10};
    #1 chk(berr == 1'b1, "R8 one slot over", berr, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule